// File: doc/BRIEF.md
# Structured sparsity gather and tag packer

This block turns one group of sixteen dense 8-bit elements into four kept values plus a 16-bit index tag. A keep mask arrives with every group and alone decides which elements survive: the block performs no comparison of magnitudes, no top-k and no thresholding. It moves the four marked elements into four output lanes. It records the dense column (0 to 15) of each one as a 4-bit field of the tag. Within a 128-column window the packed order runs downward from column 127, so the lane that is packed first holds the lowest kept index.

A mask that does not mark exactly four elements is malformed. In that case the beat still passes through the handshake, but its values and tag are zero and an error flag is raised alongside it. Each output beat also carries the window column of its first packed nibble, counted down from 127 in steps of sixteen and restarting at every window boundary.

Both the input and the output use valid/ready handshakes. A beat transfers on any rising edge where valid and ready are both high. The output is registered, so a beat accepted on one edge appears on the output after that edge. While the output holds a beat that has not been taken, `in_ready` is low, and the output beat stays unchanged until `out_ready` takes it. An input beat that is presented while `in_ready` is low is not consumed and must be held.

Top module: `sps_pack`

## Requirements
- R1: Each accepted input beat of sixteen elements yields exactly one output beat of four lanes (a 4:1 ratio), and `out_valid` is high in the cycle after the input transfer.
- R2: Lane j of `out_vals` is bits [8j+7:8j], and lane j of `out_tag` is bits [4j+3:4j] (lane 0 in [3:0], lane 3 in [15:12]). The tag nibble of a lane is the dense index i of the value in that lane. Input element i is `in_data` bits [8i+7:8i].
- R3: The order of the kept indices is flipped: lane 3 holds the lowest kept index and lane 0 holds the highest. As a result, the tag read as hex from the top nibble down lists the kept indices in ascending order.
- R4: The kept set is exactly the set bits of `in_mask` (bit i keeps element i), whatever the element values are.
- R5: If the mask does not have exactly four set bits, `out_err` is 1 and both `out_vals` and `out_tag` are zero. The beat is still accepted and still delivered through the handshake.
- R6: A mask with fewer than four set bits, including an all-zero mask, is rejected with `out_err` = 1, because a complete group of four cannot be formed. A mask with exactly four set bits gives `out_err` = 0.
- R7: `out_wcol` equals 127 − 16·(n mod 8), where n is the number of input beats accepted since reset before this beat. The value restarts at 127 at each 128-column window.
- R8: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. While that stall lasts, every output holds its value.
- R9: After reset, `out_valid` is 0, `in_ready` is 1 and the window column counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 128 | Sixteen dense 8-bit elements, element i at [8i+7:8i] |
| in_mask | input | 16 | Keep mask, bit i keeps element i |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_vals | output | 32 | Four kept values, lane j at [8j+7:8j] |
| out_tag | output | 16 | Four 4-bit dense indices, lane j at [4j+3:4j] |
| out_err | output | 1 | Mask did not mark exactly four elements |
| out_wcol | output | 7 | Window column of the first packed nibble |

## Verification
The gather is driven with masks whose four kept elements sit in different places:
- a packed run at the bottom and a packed run at the top of the group, which expose any error in the lane order and in the end indices;
- evenly spread and irregular masks, which separate a correct rank-based lane assignment from one that depends on position;
- a run in the middle of the group.

Malformed masks with popcounts of 0, 1, 3, 5 and 16 tell under-full groups apart from over-full ones. The window column is followed across more than eight beats, which shows its wrap, and again across a reset. A stalled output with a second beat waiting shows that nothing is consumed and that the output holds until the stall is released.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int DEF_GROUP = 16;
  localparam int DEF_KEEP  = 4;
  localparam int DEF_EW    = 8;
  localparam int DEF_WIN   = 128;
  localparam bit DEF_FLIP  = 1'b1;
endpackage

// File: rtl/sps_rank.sv
module sps_rank #(
  parameter int GROUP = 16,
  localparam int CNTW = $clog2(GROUP + 1)
) (
  input  logic [GROUP-1:0]      mask,
  output logic [GROUP*CNTW-1:0] rank,
  output logic [CNTW-1:0]       total
);
  logic [CNTW-1:0] pre [GROUP+1];

  assign pre[0] = '0;
  for (genvar i = 0; i < GROUP; i++) begin : g_pre
    assign pre[i+1] = pre[i] + CNTW'(mask[i]);
    assign rank[i*CNTW +: CNTW] = pre[i];
  end
  assign total = pre[GROUP];
endmodule

// File: rtl/sps_gather.sv
module sps_gather #(
  parameter int GROUP = 16,
  parameter int KEEP  = 4,
  parameter int EW    = 8,
  parameter bit FLIP  = 1'b1,
  localparam int CNTW = $clog2(GROUP + 1),
  localparam int IDXW = $clog2(GROUP)
) (
  input  logic [GROUP*EW-1:0]   data,
  input  logic [GROUP-1:0]      mask,
  input  logic [GROUP*CNTW-1:0] rank,
  input  logic [CNTW-1:0]       total,
  output logic [KEEP*EW-1:0]    vals,
  output logic [KEEP*IDXW-1:0]  tag,
  output logic                  err
);
  assign err = (total != CNTW'(KEEP));

  for (genvar j = 0; j < KEEP; j++) begin : g_lane
    localparam int SLOT = FLIP ? (KEEP - 1 - j) : j;
    logic [IDXW-1:0] idx;
    logic [EW-1:0]   val;

    always_comb begin
      idx = '0;
      val = '0;
      for (int i = 0; i < GROUP; i++) begin
        if (mask[i] && (rank[i*CNTW +: CNTW] == CNTW'(SLOT))) begin
          idx = IDXW'(i);
          val = data[i*EW +: EW];
        end
      end
    end

    assign vals[j*EW +: EW]     = err ? '0 : val;
    assign tag[j*IDXW +: IDXW]  = err ? '0 : idx;
  end
endmodule

// File: rtl/sps_wincol.sv
module sps_wincol #(
  parameter int GROUP = 16,
  parameter int WIN   = 128,
  localparam int CW   = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] col_desc
);
  logic [CW-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base <= '0;
    else if (step) base <= base + CW'(GROUP);
  end

  assign col_desc = CW'(WIN - 1) - base;
endmodule

// File: rtl/sps_outreg.sv
module sps_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/sps_pack.sv
module sps_pack
  import sps_pkg::*;
#(
  parameter int GROUP = DEF_GROUP,
  parameter int KEEP  = DEF_KEEP,
  parameter int EW    = DEF_EW,
  parameter int WIN   = DEF_WIN,
  parameter bit FLIP  = DEF_FLIP,
  localparam int CNTW = $clog2(GROUP + 1),
  localparam int IDXW = $clog2(GROUP),
  localparam int CW   = $clog2(WIN),
  localparam int PW   = CW + 1 + KEEP*IDXW + KEEP*EW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [GROUP*EW-1:0]  in_data,
  input  logic [GROUP-1:0]     in_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [KEEP*EW-1:0]   out_vals,
  output logic [KEEP*IDXW-1:0] out_tag,
  output logic                 out_err,
  output logic [CW-1:0]        out_wcol
);
  logic [GROUP*CNTW-1:0] rank;
  logic [CNTW-1:0]       total;
  logic [KEEP*EW-1:0]    g_vals;
  logic [KEEP*IDXW-1:0]  g_tag;
  logic                  g_err;
  logic [CW-1:0]         col_desc;
  logic [PW-1:0]         pay_in;
  logic [PW-1:0]         pay_out;

  sps_rank #(.GROUP(GROUP)) u_rank (
    .mask(in_mask), .rank(rank), .total(total)
  );

  sps_gather #(.GROUP(GROUP), .KEEP(KEEP), .EW(EW), .FLIP(FLIP)) u_gather (
    .data(in_data), .mask(in_mask), .rank(rank), .total(total),
    .vals(g_vals), .tag(g_tag), .err(g_err)
  );

  sps_wincol #(.GROUP(GROUP), .WIN(WIN)) u_wincol (
    .clk(clk), .rst_n(rst_n), .step(in_valid && in_ready), .col_desc(col_desc)
  );

  assign pay_in = {col_desc, g_err, g_tag, g_vals};

  sps_outreg #(.W(PW)) u_outreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign {out_wcol, out_err, out_tag, out_vals} = pay_out;
endmodule

// File: rtl/sps_pack_chk.sv
module sps_pack_chk #(
  parameter int GROUP = 16,
  parameter int KEEP  = 4,
  parameter int EW    = 8,
  parameter bit FLIP  = 1'b1,
  localparam int IDXW = $clog2(GROUP)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [GROUP-1:0]     in_mask,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [KEEP*EW-1:0]   out_vals,
  input logic [KEEP*IDXW-1:0] out_tag,
  input logic                 out_err
);
  logic ordered;
  always_comb begin
    ordered = 1'b1;
    for (int j = 0; j < KEEP - 1; j++) begin
      if (FLIP) begin
        if (!(out_tag[j*IDXW +: IDXW] > out_tag[(j+1)*IDXW +: IDXW])) ordered = 1'b0;
      end else begin
        if (!(out_tag[j*IDXW +: IDXW] < out_tag[(j+1)*IDXW +: IDXW])) ordered = 1'b0;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> ordered);

  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_tag == '0 && out_vals == '0));

  p_err_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_err == ($countones($past(in_mask)) != KEEP)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_vals) && $stable(out_err)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind sps_pack sps_pack_chk #(.GROUP(GROUP), .KEEP(KEEP), .EW(EW), .FLIP(FLIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_vals(out_vals), .out_tag(out_tag), .out_err(out_err)
);

// File: tb/tb_sps_pack.sv
`timescale 1ns/100ps
module tb_sps_pack;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [15:0]  in_mask = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_vals;
  logic [15:0]  out_tag;
  logic         out_err;
  logic [6:0]   out_wcol;

  int n_checks = 0;
  int n_fail   = 0;
  int n_beats  = 0;

  always #2.5 clk = ~clk;

  sps_pack dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_vals(out_vals), .out_tag(out_tag),
    .out_err(out_err), .out_wcol(out_wcol)
  );

  localparam int NV = 10;
  localparam logic [15:0] T_MASK [NV] = '{16'h000F, 16'hF000, 16'h8421, 16'h1248, 16'h0007,
                                           16'h001F, 16'h0000, 16'hFFFF, 16'hA005, 16'h0F00};
  localparam logic [15:0] T_TAG  [NV] = '{16'h0123, 16'hCDEF, 16'h05AF, 16'h369C, 16'h0000,
                                           16'h0000, 16'h0000, 16'h0000, 16'h02DF, 16'h89AB};
  localparam logic        T_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                           1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_data(input int v);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[i*8 +: 8] = {4'(v), 4'(i)};
    return d;
  endfunction

  function automatic logic [31:0] exp_vals(input int v, input logic [15:0] tag, input logic err);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = err ? 8'h00 : {4'(v), tag[j*4 +: 4]};
    return r;
  endfunction

  function automatic logic [6:0] exp_wcol(input int n);
    return 7'(127 - 16 * (n % 8));
  endfunction

  task automatic check_beat(input string req, input int v, input logic [15:0] tag,
                            input logic err, input logic [6:0] wcol);
    logic [63:0] act;
    logic [63:0] exp;
    act = {out_valid, out_err, out_wcol, out_tag, out_vals};
    exp = {1'b1, err, wcol, tag, exp_vals(v, tag, err)};
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      in_valid = 1'b1;
      in_mask  = T_MASK[k];
      in_data  = mk_data(k);
      @(negedge clk);
      in_valid = 1'b0;
      check_beat("R1 R2 R3 R4 R5 R6 R7 table", k, T_TAG[k], T_ERR[k], exp_wcol(n_beats));
      n_beats++;
      @(negedge clk);
    end

    // R1: output drains after one-beat transfer
    chk(out_valid == 1'b0, "R1 single beat", {63'd0, out_valid}, 64'd0);

    // R8: back-pressure
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_mask   = 16'h000F;
    in_data   = mk_data(1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 ready low on stall", {63'd0, in_ready}, 64'd0);
    in_mask = 16'hF000;
    in_data = mk_data(2);
    @(negedge clk);
    check_beat("R8 hold during stall", 1, 16'h0123, 1'b0, exp_wcol(n_beats));
    n_beats++;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_beat("R8 next beat after release", 2, 16'hCDEF, 1'b0, exp_wcol(n_beats));
    n_beats++;
    @(negedge clk);

    // R5: malformed beat completes handshake
    in_valid = 1'b1;
    in_mask  = 16'h0001;
    in_data  = mk_data(3);
    @(negedge clk);
    in_valid = 1'b0;
    check_beat("R5 single-bit mask", 3, 16'h0000, 1'b1, exp_wcol(n_beats));
    n_beats++;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 err beat consumed", {63'd0, out_valid}, 64'd0);

    // R4: same mask, different element values
    in_valid = 1'b1;
    in_mask  = 16'h8421;
    in_data  = mk_data(14);
    @(negedge clk);
    in_valid = 1'b0;
    check_beat("R4 mask-only selection", 14, 16'h05AF, 1'b0, exp_wcol(n_beats));
    n_beats++;
    @(negedge clk);

    // R9 R7: reset mid-run restarts window column
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 reset mid-run", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    n_beats = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_mask  = 16'h0F00;
    in_data  = mk_data(5);
    @(negedge clk);
    in_valid = 1'b0;
    check_beat("R7 window restart after reset", 5, 16'h89AB, 1'b0, 7'd127);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule